// File: doc/BRIEF.md
# Embedded Program/Erase Sequencer

This block carries out byte-program, sector-erase and chip-erase requests that an upstream command decoder has already recognised, and applies them to a small flash-style byte array held in registers. Each operation takes a fixed number of clock cycles, set by a parameter, to stand in for the internal timing of a real cell array. `busy` is high for that whole interval. The result is written into the array on the last busy cycle. Any request that arrives while the block is busy is dropped.

While an operation is running, the read port does not return array contents. It returns a status byte instead, so that software can watch for completion in two ways: by comparing bit 7 with the data it wrote, or by watching bit 6 toggle. The array is split into five sectors of unequal size. The split is taken from the five most significant address bits, so the same map scales with the array size. A boot sector can be guarded by a lock input, and a synchronous reset aborts whatever operation is in flight.

The parameter `TOP_BOOT` mirrors the sector map so that the boot sector sits at the top of the address space. The defaults are a 128-byte array, 4 cycles per program and 40 cycles per erase.

Top module: `flash_seq`

## Requirements
- R1: A program operation (`req_op`=0) stores the old byte AND `req_data` at `req_addr`. Bits can only go from 1 to 0, and programming a byte twice accumulates the zeros.
- R2: A sector erase (`req_op`=1) sets every byte of the sector that contains `req_addr` to FFh and leaves all other sectors alone. The sector is chosen by unit u = the top five address bits (with a 128-byte array, u = addr>>2). u 0–1 is the boot sector, u 2 is parameter sector A, u 3 is parameter sector B, u 4–15 is main sector A, and u 16–31 is main sector B.
- R3: A sector erase whose address falls in the boot sector is ignored: `busy` stays low and no byte changes.
- R4: A chip erase (`req_op`=2) sets every byte to FFh when `lock_in` was low at acceptance. When `lock_in` was high at acceptance, the boot sector keeps its contents and every other byte becomes FFh.
- R5: A program aimed at the boot sector while `lock_in` is high is ignored. With `lock_in` low the same program is carried out.
- R6: An accepted request raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for either erase, and a new result is visible once `busy` is low.
- R7: A read accepted while busy returns a status byte with bits 5..0 at zero. Bit 7 is the complement of bit 7 of the loaded data during a program, and 0 during an erase.
- R8: Bit 6 of the status byte is inverted on each read accepted while busy, with a first value of 1 after reset. Reads made while idle return array data and do not change the toggle.
- R9: A request of any kind that arrives while `busy` is high is ignored. `req_op`=3 is never accepted.
- R10: Raising `rst` during an operation drops `busy` on the next cycle and leaves the targeted bytes unchanged, so the operation has to be issued again.
- R11: After reset `busy` is 0 and `rd_data` is 00h.
- R12: A read is taken when `rd_en` is high at a clock edge, and its result appears on `rd_data` after that edge. `rd_data` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running operation |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Program data |
| lock_in | input | 1 | Boot sector lock |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result or polling status |
| busy | output | 1 | Operation in progress |

## Verification
A wrong sector decode or a wrong lock decision shows up only as a byte that has the wrong value. That error is visible at the first read of that address after `busy` falls, which may be as late as the final sweep over the whole array. A miscounted timer is visible at once, because `busy` is compared every cycle and so fails on the exact cycle it goes wrong. A stuck or doubled toggle, or a wrong polling bit 7, shows up one cycle after the next read that is made while busy. A reset that fails to abort shows up as `busy` still being high one cycle after `rst`.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int UNIT_W = 5;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RG_BOOT   = 3'd0,
        RG_PAR_A  = 3'd1,
        RG_PAR_B  = 3'd2,
        RG_MAIN_A = 3'd3,
        RG_MAIN_B = 3'd4
    } region_e;

    // Operation context captured at acceptance
    typedef struct packed {
        op_e       op;
        region_e   region;
        logic      keep_boot;
        logic [7:0] data;
    } op_ctx_t;

    // Map a 1/32-of-array unit to its sector; top variant mirrors the units
    function automatic region_e region_of(logic [UNIT_W-1:0] unit, logic top);
        logic [UNIT_W-1:0] u;
        u = top ? ~unit : unit;
        if (u < 5'd2)       return RG_BOOT;
        else if (u == 5'd2) return RG_PAR_A;
        else if (u == 5'd3) return RG_PAR_B;
        else if (u < 5'd16) return RG_MAIN_A;
        else                return RG_MAIN_B;
    endfunction

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_seq_pkg::*;
#(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_op,
    output logic busy,
    output logic done
);
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= long_op ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        end
    end

    assign done = busy && (cnt_q == '0);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int TOP_BOOT = 0
) (
    input  logic              clk,
    input  logic              commit,
    input  op_ctx_t           ctx,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SHIFT = ADDR_W - UNIT_W;

    // Nonvolatile cells: no reset
    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                region_e rg;
                rg = region_of(UNIT_W'(i >> SHIFT), TOP_BOOT[0]);
                case (ctx.op)
                    OP_PROG: if (ADDR_W'(i) == tgt_addr)
                                 cell_q[i] <= cell_q[i] & ctx.data;
                    OP_SECT: if (rg == ctx.region)
                                 cell_q[i] <= 8'hFF;
                    OP_CHIP: if (!(ctx.keep_boot && rg == RG_BOOT))
                                 cell_q[i] <= 8'hFF;
                    default: ;
                endcase
            end
        end
    end

    assign rd_byte = cell_q[rd_addr];

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       is_prog,
    input  logic       inv_bit7,
    input  logic [7:0] cell_byte,
    output logic [7:0] rd_data
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q   <= 1'b0;
            rd_data <= 8'h00;
        end else if (rd_en) begin
            if (busy) begin
                tog_q   <= ~tog_q;
                rd_data <= {is_prog ? inv_bit7 : 1'b0, ~tog_q, 6'b0};
            end else begin
                rd_data <= cell_byte;
            end
        end
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 40,
    parameter int TOP_BOOT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              lock_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    op_e               req_kind;
    region_e           req_region;
    logic              accept;
    logic              done;
    op_ctx_t           ctx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        cell_byte;

    assign req_kind   = op_e'(req_op);
    assign req_region = region_of(req_addr[ADDR_W-1 -: UNIT_W], TOP_BOOT[0]);

    always_comb begin
        accept = 1'b0;
        if (req_valid && !busy) begin
            case (req_kind)
                OP_PROG: accept = !(lock_in && req_region == RG_BOOT);
                OP_SECT: accept = (req_region != RG_BOOT);
                OP_CHIP: accept = 1'b1;
                default: accept = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{op: OP_NONE, region: RG_BOOT, keep_boot: 1'b1, data: 8'hFF};
            addr_q <= '0;
        end else if (accept) begin
            ctx_q  <= '{op: req_kind, region: req_region, keep_boot: lock_in, data: req_data};
            addr_q <= req_addr;
        end
    end

    flash_op_timer #(
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .long_op(req_kind != OP_PROG),
        .busy   (busy),
        .done   (done)
    );

    flash_cell_array #(
        .ADDR_W  (ADDR_W),
        .TOP_BOOT(TOP_BOOT)
    ) cells_i (
        .clk     (clk),
        .commit  (done && !rst),
        .ctx     (ctx_q),
        .tgt_addr(addr_q),
        .rd_addr (rd_addr),
        .rd_byte (cell_byte)
    );

    flash_poll_status poll_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .busy     (busy),
        .is_prog  (ctx_q.op == OP_PROG),
        .inv_bit7 (~ctx_q.data[7]),
        .cell_byte(cell_byte),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 40,
    parameter int TOP_BOOT  = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              lock_in,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              busy
);
    logic    ok_q;
    int      run_q;
    region_e rg;

    assign rg = region_of(req_addr[ADDR_W-1 -: UNIT_W], TOP_BOOT[0]);

    always_ff @(posedge clk) begin
        ok_q <= !rst;
        if (rst || !busy) run_q <= 0;
        else              run_q <= run_q + 1;
    end

    assert_boot_sector_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == 2'd1 && rg == RG_BOOT) |=> !busy);

    assert_locked_prog_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == 2'd0 && lock_in && rg == RG_BOOT) |=> !busy);

    assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
        (ok_q && $rose(busy)) |-> $past(req_valid));

    assert_busy_length_R6: assert property (@(posedge clk) disable iff (rst)
        (ok_q && $fell(busy)) |-> (run_q == PROG_CYC || run_q == ERASE_CYC));

    assert_poll_low_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rd_data[5:0] == 6'd0));

    assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (rst)
        (ok_q && rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

    assert_reset_abort_R10: assert property (@(posedge clk)
        rst |=> !busy);

endmodule

bind flash_seq flash_seq_chk #(
    .ADDR_W   (ADDR_W),
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC),
    .TOP_BOOT (TOP_BOOT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .lock_in  (lock_in),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .busy     (busy)
);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
    localparam int CLK_P     = 10;
    localparam int AW        = 7;
    localparam int DEPTH     = 1 << AW;
    localparam int PROG_CYC  = 4;
    localparam int ERASE_CYC = 40;
    localparam int WDOG      = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd3;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          lock_in = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_req = "R11";

    // Reference model state
    logic [7:0] mem [DEPTH];
    bit         known [DEPTH];
    bit         m_busy = 0;
    int         m_cnt  = 0;
    int         p_op = 3, p_addr = 0;
    logic [7:0] p_data = 8'h00;
    bit         p_keep = 0;
    bit         tog = 0;
    logic [7:0] exp_rd = 8'h00;
    bit         exp_known = 1;

    always #(CLK_P/2) clk = ~clk;

    flash_seq #(.ADDR_W(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TOP_BOOT(0)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .lock_in(lock_in), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    function automatic int sector(int a);
        int u;
        u = a >> (AW - 5);
        if (u < 2)       return 0;
        else if (u == 2) return 1;
        else if (u == 3) return 2;
        else if (u < 16) return 3;
        else             return 4;
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]   = 8'hFF;
            known[i] = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_cnt = 0; tog = 0; exp_rd = 8'h00; exp_known = 1;
        end else begin
            if (rd_en) begin
                if (m_busy) begin
                    tog = !tog;
                    exp_rd = {(p_op == 0) ? ~p_data[7] : 1'b0, tog, 6'b0};
                    exp_known = 1;
                end else begin
                    exp_rd = mem[rd_addr];
                    exp_known = known[rd_addr];
                end
            end
            if (m_busy) begin
                if (m_cnt == 0) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        if (p_op == 0 && j == p_addr) mem[j] = mem[j] & p_data;
                        if (p_op == 1 && sector(j) == sector(p_addr)) begin
                            mem[j] = 8'hFF; known[j] = 1;
                        end
                        if (p_op == 2 && !(p_keep && sector(j) == 0)) begin
                            mem[j] = 8'hFF; known[j] = 1;
                        end
                    end
                    m_busy = 0;
                end else begin
                    m_cnt--;
                end
            end else if (req_valid) begin
                bit acc;
                acc = 0;
                if (req_op == 2'd0) acc = !(lock_in && sector(req_addr) == 0);
                if (req_op == 2'd1) acc = (sector(req_addr) != 0);
                if (req_op == 2'd2) acc = 1;
                if (acc) begin
                    p_op = req_op; p_addr = req_addr; p_data = req_data; p_keep = lock_in;
                    m_busy = 1;
                    m_cnt = ((req_op == 2'd0) ? PROG_CYC : ERASE_CYC) - 1;
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        n_cmp++;
        if (busy !== m_busy) begin
            n_bad++;
            $display("FAIL %s busy: actual %b expected %b (t=%0t)", cur_req, busy, m_busy, $time);
        end
        if (exp_known) begin
            n_cmp++;
            if (rd_data !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rd_data: actual %h expected %h (t=%0t)", cur_req, rd_data, exp_rd, $time);
            end
        end
    end

    task automatic do_req(input logic [1:0] op, input int a, input logic [7:0] d);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3;
    endtask

    task automatic do_read(input int a);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc >= WDOG);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
        finish_run();
    end

    initial begin
        // R11: reset state
        cur_req = "R11";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4: unlocked chip erase initialises everything; R6 timing observed per cycle
        cur_req = "R4";
        lock_in = 1'b0;
        do_req(2'd2, 0, 8'h00);
        wait_idle();
        do_read(0);
        do_read(127);

        // R1: program ANDs; R7/R8 polling during program; R12 latency
        cur_req = "R1";
        do_req(2'd0, 20, 8'hA5);
        cur_req = "R7";
        do_read(20);
        cur_req = "R8";
        do_read(21);
        do_read(22);
        wait_idle();
        cur_req = "R12";
        do_read(20);
        @(negedge clk);
        cur_req = "R1";
        do_req(2'd0, 20, 8'h3C);
        wait_idle();
        do_read(20);
        do_req(2'd0, 21, 8'h7F);
        cur_req = "R7";
        do_read(21);
        wait_idle();
        do_read(21);

        // R5: locked boot program ignored, unlocked allowed
        cur_req = "R5";
        lock_in = 1'b1;
        do_req(2'd0, 2, 8'h00);
        @(negedge clk);
        do_read(2);
        lock_in = 1'b0;
        do_req(2'd0, 2, 8'h0F);
        wait_idle();
        do_read(2);

        // R9: requests while busy ignored; op 3 never accepted
        cur_req = "R9";
        do_req(2'd0, 30, 8'h00);
        do_req(2'd0, 31, 8'h00);
        do_req(2'd2, 0, 8'h00);
        wait_idle();
        do_read(30);
        do_read(31);
        do_req(2'd3, 31, 8'h00);
        @(negedge clk);
        do_read(31);

        // R3: sector erase aimed at boot does nothing
        cur_req = "R3";
        do_req(2'd1, 5, 8'h00);
        @(negedge clk);
        do_read(2);

        // R2: sector erase of parameter A and main A only
        cur_req = "R2";
        do_req(2'd0, 9, 8'h00);  wait_idle();
        do_req(2'd0, 13, 8'h00); wait_idle();
        do_req(2'd0, 70, 8'h11); wait_idle();
        do_req(2'd1, 10, 8'h00);
        cur_req = "R7";
        do_read(9);
        cur_req = "R8";
        do_read(9);
        do_read(9);
        wait_idle();
        cur_req = "R2";
        do_read(9);
        do_read(13);
        do_req(2'd1, 40, 8'h00); wait_idle();
        do_read(20);
        do_read(30);
        do_read(70);
        do_read(2);

        // R4: locked chip erase keeps boot
        cur_req = "R4";
        lock_in = 1'b1;
        do_req(2'd2, 0, 8'h00);
        lock_in = 1'b0;
        wait_idle();
        do_read(2);
        do_read(13);
        do_read(70);

        // R10: reset aborts program and erase
        cur_req = "R10";
        do_req(2'd0, 50, 8'h00);
        @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        @(negedge clk);
        do_read(50);
        do_req(2'd0, 2, 8'h00); wait_idle();
        do_req(2'd2, 0, 8'h00);
        repeat (10) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        @(negedge clk);
        do_read(2);
        do_read(50);

        // Final sweep of the whole array
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) do_read(i);
        @(negedge clk);
        finish_run();
    end

endmodule